// File: doc/BRIEF.md
# Link-Side Grant and Transmit Sequencer

This block is the part of a serial-bus link layer that takes over the shared link-to-PHY interface once the PHY has won arbitration for the link's bus request. It watches the two PHY-driven control lines for the grant handshake. It then drives the control lines and the data byte lane itself to send one packet from an upstream packet source. When the packet is done, it hands the interface back to the PHY by releasing its output enables.

The packet source gives four signals. A pending flag says a packet is waiting. A valid flag marks each data byte. A last flag marks the final byte. A concatenate flag is sampled with that last byte. The sequencer accepts a byte on each cycle where both valid and ready are high. Once transmission starts, the source is expected to supply one byte per cycle until the last byte. If a byte is missing mid-packet, the byte already on the lane is repeated.

A concatenate request ends the packet with a hold code instead of an idle code. After that the interface is released as usual, and the next grant starts the following packet.

Top module: `link_grant_tx`

## Requirements
- R1: While reset is held, both output enables are low, the control and data outputs are zero, and `src_ready_o` is low.
- R2: A grant is recognised only when the PHY drives code 2'b11 for one cycle and 2'b00 in the next cycle. Code 2'b11 followed by any other code does not raise the output enables.
- R3: The output enables go high in the cycle after the grant's idle cycle, which is two cycles after the 2'b11 cycle. They stay high through the final idle cycle and drop in the cycle after it.
- R4: If a byte is valid during the grant's idle cycle, the first owned cycle drives transmit (2'b10) with that byte, with no idle and no hold before it.
- R5: If a packet is pending but no byte is valid, hold (2'b01) is driven for each such cycle. Transmit with the first byte follows in the cycle after the byte becomes valid.
- R6: Transmit (2'b10) is driven on consecutive cycles, one accepted byte per cycle, up to and including the byte flagged last.
- R7: After the last byte, the block drives one cycle of 2'b00, or 2'b01 if concatenate was set with the last byte. It then drives one cycle of 2'b00 and then releases both enables.
- R8: If no packet is pending at grant, the block drives one owned cycle of idle 2'b00 and then releases the interface.
- R9: In every owned cycle that is not a transmit cycle, the data lane is driven to zero.
- R10: While the interface is owned, the PHY control input is ignored, including a further 2'b11-then-2'b00 pattern. The owned sequence on the outputs is unchanged by it.
- R11: After a concatenated packet has released the interface, a new grant starts the next packet with the same timing as R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_ctl_i | input | 2 | Control lines as driven by the PHY |
| src_pending_i | input | 1 | Source has a packet to send |
| src_valid_i | input | 1 | Source byte on `src_data_i` is valid |
| src_data_i | input | DATA_W | Source packet byte |
| src_last_i | input | 1 | Current source byte is the last of the packet |
| src_concat_i | input | 1 | With the last byte: request a concatenated follow-on packet |
| src_ready_o | output | 1 | Sequencer accepts the byte this cycle |
| link_ctl_o | output | 2 | Control code driven by the link |
| link_ctl_oe_o | output | 1 | Output enable for the control lines |
| link_data_o | output | DATA_W | Byte driven onto the data lane |
| link_data_oe_o | output | 1 | Output enable for the data lane |

## Verification
The bench builds the block with the default byte lane of eight bits. With that width, every byte value the bench picks appears unchanged on the data lane and can be matched one to one against the scoreboard.

The bench runs packets of length zero, one, two, three, four and six bytes, with zero to three hold cycles before the first byte. These runs bring within reach the direct-transmit start, the hold start, the immediate release, a single-byte packet whose first byte is also its last, and a concatenated pair.

A false grant pattern is also driven, and a second grant pattern is injected in the middle of a packet. These two cases cover grant recognition and the rule that the PHY input is ignored while the interface is owned.

// File: rtl/lbg_pkg.sv
// Package: shared codes and states for the link grant/transmit sequencer.
// Assumes the two-bit control-line encoding used on the link-to-PHY interface.
package lbg_pkg;

    // Control-line codes; the values are fixed by the interface.
    typedef enum logic [1:0] {
        LCTL_IDLE  = 2'b00,
        LCTL_HOLD  = 2'b01,
        LCTL_XMIT  = 2'b10,
        LCTL_GRANT = 2'b11
    } lctl_e;

    // Sequencer state: names the drive that is currently on the pins.
    typedef enum logic [2:0] {
        ST_PHY   = 3'd0,  // interface belongs to the PHY
        ST_HOLD  = 3'd1,  // owned, waiting for the first byte
        ST_XMIT  = 3'd2,  // owned, sending bytes
        ST_TAIL1 = 3'd3,  // first post-packet cycle (idle or hold)
        ST_TAIL2 = 3'd4,  // final idle before release
        ST_DROP  = 3'd5   // nothing to send: one idle then release
    } tx_state_e;

endpackage

// File: rtl/lbg_grant_det.sv
// Grant detector: spots the PHY's grant code followed by idle.
// Assumes: phy_ctl_i is synchronous to clk; armed is high only while the
// PHY owns the interface, so a pattern seen while owned is ignored.
module lbg_grant_det (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] phy_ctl_i,
    input  logic       armed_i,
    output logic       grant_o
);
    import lbg_pkg::*;

    logic [1:0] prev_q;

    // Remember last cycle's control code from the PHY.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= LCTL_IDLE;
        else        prev_q <= phy_ctl_i;
    end

    // Grant = grant code last cycle, idle this cycle, while armed.
    always_comb begin
        grant_o = armed_i && (prev_q == LCTL_GRANT) && (phy_ctl_i == LCTL_IDLE);
    end

endmodule

// File: rtl/lbg_seq.sv
// Sequencer: decides next cycle's drive on the link interface and accepts
// source bytes. Assumes the source keeps bytes valid back to back once the
// first byte is sent; a gap repeats the byte already on the lane.
module lbg_seq (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 grant_i,
    input  logic                 src_pending_i,
    input  logic                 src_valid_i,
    input  logic                 src_last_i,
    input  logic                 src_concat_i,
    output logic                 src_ready_o,
    output logic                 accept_o,
    output lbg_pkg::tx_state_e   state_d_o,
    output lbg_pkg::tx_state_e   state_q_o,
    output logic                 concat_q_o
);
    import lbg_pkg::*;

    tx_state_e state_q, state_d;
    logic      last_q;
    logic      concat_q;
    logic      ready;
    logic      accept;

    // Ready: at grant with a packet pending, while holding, or mid-packet.
    always_comb begin
        ready = 1'b0;
        unique case (state_q)
            ST_PHY:  ready = grant_i && src_pending_i;
            ST_HOLD: ready = 1'b1;
            ST_XMIT: ready = !last_q;
            default: ready = 1'b0;
        endcase
        accept = ready && src_valid_i;
    end

    // Next-state selection for the interface ownership sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PHY: begin
                if (grant_i) begin
                    if (!src_pending_i)   state_d = ST_DROP;
                    else if (src_valid_i) state_d = ST_XMIT;
                    else                  state_d = ST_HOLD;
                end
            end
            ST_HOLD:  if (src_valid_i) state_d = ST_XMIT;
            ST_XMIT:  if (last_q)      state_d = ST_TAIL1;
            ST_TAIL1: state_d = ST_TAIL2;
            ST_TAIL2: state_d = ST_PHY;
            ST_DROP:  state_d = ST_PHY;
            default:  state_d = ST_PHY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PHY;
        else        state_q <= state_d;
    end

    // Track whether the byte on the lane is the last one of the packet.
    always_ff @(posedge clk) begin
        if (!rst_n)                 last_q <= 1'b0;
        else if (accept)            last_q <= src_last_i;
        else if (state_d != ST_XMIT) last_q <= 1'b0;
    end

    // Capture the concatenate request with the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                     concat_q <= 1'b0;
        else if (accept && src_last_i)  concat_q <= src_concat_i;
    end

    assign src_ready_o = ready;
    assign accept_o    = accept;
    assign state_d_o   = state_d;
    assign state_q_o   = state_q;
    assign concat_q_o  = concat_q;

endmodule

// File: rtl/lbg_pin_drv.sv
// Pin driver: registers the control code, data byte and output enables
// from the sequencer's next state, so every pin comes straight from a flop.
// Assumes state_d names the drive intended for the next cycle.
module lbg_pin_drv #(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  lbg_pkg::tx_state_e state_d_i,
    input  logic               concat_i,
    input  logic               accept_i,
    input  logic [DATA_W-1:0]  byte_i,
    output logic [1:0]         ctl_o,
    output logic               ctl_oe_o,
    output logic [DATA_W-1:0]  data_o,
    output logic               data_oe_o
);
    import lbg_pkg::*;

    logic [1:0]        ctl_d, ctl_q;
    logic              oe_d, oe_q;
    logic [DATA_W-1:0] data_d, data_q;

    // Decode next cycle's control code and enable from the next state.
    always_comb begin
        ctl_d = LCTL_IDLE;
        unique case (state_d_i)
            ST_HOLD:  ctl_d = LCTL_HOLD;
            ST_XMIT:  ctl_d = LCTL_XMIT;
            ST_TAIL1: ctl_d = concat_i ? LCTL_HOLD : LCTL_IDLE;
            default:  ctl_d = LCTL_IDLE;
        endcase
        oe_d = (state_d_i != ST_PHY);
    end

    // Data byte: new byte on accept, kept while sending, zero otherwise.
    always_comb begin
        if (accept_i)                 data_d = byte_i;
        else if (state_d_i == ST_XMIT) data_d = data_q;
        else                          data_d = '0;
    end

    // Output flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= LCTL_IDLE;
            oe_q   <= 1'b0;
            data_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            oe_q   <= oe_d;
            data_q <= data_d;
        end
    end

    assign ctl_o     = ctl_q;
    assign ctl_oe_o  = oe_q;
    assign data_o    = data_q;
    assign data_oe_o = oe_q;

endmodule

// File: rtl/link_grant_tx.sv
// Top: link-side grant and transmit sequencer. Detects the PHY grant,
// owns the interface for one packet (or a one-cycle idle if nothing is
// pending) and releases it. Assumes a single clock domain with the PHY.
module link_grant_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        phy_ctl_i,
    input  logic              src_pending_i,
    input  logic              src_valid_i,
    input  logic [DATA_W-1:0] src_data_i,
    input  logic              src_last_i,
    input  logic              src_concat_i,
    output logic              src_ready_o,
    output logic [1:0]        link_ctl_o,
    output logic              link_ctl_oe_o,
    output logic [DATA_W-1:0] link_data_o,
    output logic              link_data_oe_o
);
    import lbg_pkg::*;

    logic      grant;
    logic      armed;
    logic      accept;
    logic      concat_q;
    tx_state_e state_d, state_q;

    // Grant detection is armed only while the PHY owns the interface.
    assign armed = (state_q == ST_PHY);

    lbg_grant_det u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .phy_ctl_i (phy_ctl_i),
        .armed_i   (armed),
        .grant_o   (grant)
    );

    lbg_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .grant_i       (grant),
        .src_pending_i (src_pending_i),
        .src_valid_i   (src_valid_i),
        .src_last_i    (src_last_i),
        .src_concat_i  (src_concat_i),
        .src_ready_o   (src_ready_o),
        .accept_o      (accept),
        .state_d_o     (state_d),
        .state_q_o     (state_q),
        .concat_q_o    (concat_q)
    );

    lbg_pin_drv #(.DATA_W(DATA_W)) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_d_i (state_d),
        .concat_i  (concat_q),
        .accept_i  (accept),
        .byte_i    (src_data_i),
        .ctl_o     (link_ctl_o),
        .ctl_oe_o  (link_ctl_oe_o),
        .data_o    (link_data_o),
        .data_oe_o (link_data_oe_o)
    );

endmodule

// File: rtl/lbg_checker.sv
// Checker: port-level timing rules of the grant/transmit sequence.
// A small counter keeps $past looks inside the cycles since reset.
module lbg_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        phy_ctl_i,
    input logic [1:0]        link_ctl_o,
    input logic              link_ctl_oe_o,
    input logic [DATA_W-1:0] link_data_o
);
    logic [1:0] since_rst;

    // Count clock edges since reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R3: a grant pattern seen while released raises the enables.
    a_r3_own_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(phy_ctl_i, 2) == 2'b11 &&
         $past(phy_ctl_i) == 2'b00 && !$past(link_ctl_oe_o)) |-> link_ctl_oe_o);

    // R2: the enables rise only after grant-then-idle.
    a_r2_rise_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $rose(link_ctl_oe_o)) |->
        ($past(phy_ctl_i, 2) == 2'b11 && $past(phy_ctl_i) == 2'b00));

    // R7: the cycle after the end of transmit is followed by an owned idle.
    a_r7_tail_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && $past(link_ctl_oe_o) && $past(link_ctl_o) == 2'b10 &&
         link_ctl_oe_o && link_ctl_o != 2'b10) |=> (link_ctl_oe_o && link_ctl_o == 2'b00));

    // R9: data lane is zero in owned non-transmit cycles.
    a_r9_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        (link_ctl_oe_o && link_ctl_o != 2'b10) |-> (link_data_o == '0));

    // R8: an idle first owned cycle means immediate release.
    a_r8_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && $rose(link_ctl_oe_o) && link_ctl_o == 2'b00) |=> !link_ctl_oe_o);

endmodule

bind link_grant_tx lbg_checker #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .phy_ctl_i     (phy_ctl_i),
    .link_ctl_o    (link_ctl_o),
    .link_ctl_oe_o (link_ctl_oe_o),
    .link_data_o   (link_data_o)
);

// File: tb/link_grant_tx_test.sv
`timescale 1ns/1ps
module link_grant_tx_test;

    localparam int DATA_W = 8;

    typedef struct {
        int         cyc;
        logic [1:0] ctl;
        logic [7:0] data;
        logic       oe;
        string      req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        phy_ctl = 2'b00;
    logic              src_pending, src_valid, src_last, src_concat, src_ready;
    logic [DATA_W-1:0] src_data;
    logic [1:0]        link_ctl;
    logic              link_ctl_oe, link_data_oe;
    logic [DATA_W-1:0] link_data;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    exp_t sb[$];

    // Source model state.
    bit         en = 1'b0;
    bit         cat = 1'b0;
    int         idx = 0;
    int         plen = 0;
    int         vfrom = 0;
    logic [7:0] pkt_mem [16];

    assign src_pending = en && (idx < plen);
    assign src_valid   = src_pending && (cyc >= vfrom);
    assign src_data    = pkt_mem[idx[3:0]];
    assign src_last    = (idx == plen - 1);
    assign src_concat  = cat;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    link_grant_tx #(.DATA_W(DATA_W)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .phy_ctl_i      (phy_ctl),
        .src_pending_i  (src_pending),
        .src_valid_i    (src_valid),
        .src_data_i     (src_data),
        .src_last_i     (src_last),
        .src_concat_i   (src_concat),
        .src_ready_o    (src_ready),
        .link_ctl_o     (link_ctl),
        .link_ctl_oe_o  (link_ctl_oe),
        .link_data_o    (link_data),
        .link_data_oe_o (link_data_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int c, input logic [1:0] ct, input logic [7:0] d,
                        input logic o, input string r);
        exp_t x;
        x.cyc = c; x.ctl = ct; x.data = d; x.oe = o; x.req = r;
        sb.push_back(x);
    endtask

    // Monitor: pop the expected pin state for this cycle and compare.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            if (sb[0].cyc == cyc) begin
                exp_t x;
                x = sb.pop_front();
                chk(x.req, {link_ctl, link_data, link_ctl_oe, link_data_oe},
                    {x.ctl, x.data, x.oe, x.oe});
            end else if (sb[0].cyc < cyc) begin
                exp_t x;
                x = sb.pop_front();
                chk({x.req, " missed"}, 32'd0, 32'd1);
            end
        end
    end

    // Driver: grant, packet of len bytes after holds hold cycles; optional
    // extra grant pattern at owned cycle offset pulse.
    task automatic run_pkt(input int len, input int holds, input bit cc,
                           input int pulse, input string tag_first);
        int  k, e, last_c, pulse_c;
        bit  acc;
        @(posedge clk); #1;
        k = cyc;
        for (int j = 0; j < len; j++) pkt_mem[j] = 8'(8'hA5 ^ (j * 29 + len * 3));
        idx = 0; plen = len; cat = cc; en = 1'b1; vfrom = k + 1 + holds;
        pulse_c = (pulse >= 0) ? k + 2 + pulse : -10;
        phy_ctl = 2'b11;
        if (len == 0) begin
            push(k + 2, 2'b00, 8'h00, 1'b1, "R8");
            push(k + 3, 2'b00, 8'h00, 1'b0, "R8");
            last_c = k + 3;
        end else begin
            for (int h = 0; h < holds; h++) push(k + 2 + h, 2'b01, 8'h00, 1'b1, "R5 R9");
            for (int j = 0; j < len; j++)
                push(k + 2 + holds + j, 2'b10, pkt_mem[j], 1'b1,
                     (j == 0) ? tag_first : ((pulse >= 0) ? "R10" : "R6"));
            e = k + 2 + holds + len;
            push(e,     cc ? 2'b01 : 2'b00, 8'h00, 1'b1, "R7");
            push(e + 1, 2'b00, 8'h00, 1'b1, "R7");
            push(e + 2, 2'b00, 8'h00, 1'b0, "R3");
            last_c = e + 2;
        end
        while (cyc < last_c) begin
            @(negedge clk);
            acc = src_valid && src_ready;
            @(posedge clk); #1;
            if (acc) idx++;
            phy_ctl = (cyc == pulse_c) ? 2'b11 : 2'b00;
        end
        @(negedge clk); #1;
        en = 1'b0;
    endtask

    // Driver: a grant code not followed by idle must not be taken (R2).
    task automatic no_grant();
        int k;
        @(posedge clk); #1;
        k = cyc;
        idx = 0; plen = 2; en = 1'b1; vfrom = 0; cat = 1'b0;
        pkt_mem[0] = 8'h11; pkt_mem[1] = 8'h22;
        phy_ctl = 2'b11;
        push(k + 2, 2'b00, 8'h00, 1'b0, "R2");
        push(k + 3, 2'b00, 8'h00, 1'b0, "R2");
        push(k + 4, 2'b00, 8'h00, 1'b0, "R2");
        @(posedge clk); #1; phy_ctl = 2'b01;
        @(posedge clk); #1; phy_ctl = 2'b00;
        @(posedge clk); #1;
        @(posedge clk); #1;
        @(negedge clk); #1;
        en = 1'b0;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int j = 0; j < 16; j++) pkt_mem[j] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports.
        chk("R1 ctl_oe", {31'd0, link_ctl_oe}, 32'd0);
        chk("R1 data_oe", {31'd0, link_data_oe}, 32'd0);
        chk("R1 ctl", {30'd0, link_ctl}, 32'd0);
        chk("R1 data", {24'd0, link_data}, 32'd0);
        chk("R1 ready", {31'd0, src_ready}, 32'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        run_pkt(3, 0, 1'b0, -1, "R4");   // direct transmit
        run_pkt(4, 3, 1'b0, -1, "R5");   // hold before data
        run_pkt(0, 0, 1'b0, -1, "R8");   // nothing pending
        no_grant();                      // R2 false pattern
        run_pkt(2, 0, 1'b1, -1, "R4");   // concatenate request
        run_pkt(3, 1, 1'b0, -1, "R11");  // follow-on packet
        run_pkt(6, 0, 1'b0, 1, "R10");   // grant pattern while owned
        run_pkt(1, 0, 1'b0, -1, "R4");   // single byte packet

        repeat (3) @(posedge clk);
        if (sb.size() != 0) chk("scoreboard drained", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule